// File: doc/BRIEF.md
# Configurable Two-Table Logic Cell

This block is one logic cell of a programmable fabric. It holds two 4-input lookup tables, called F and G, and a 3-input combiner table, called H. Each of F and G reads its own 4-bit input set. H takes the F result, the G result and one more input. The cell can therefore produce two independent 4-input functions. It can also produce any function of five inputs: the same four inputs go to both tables, and H picks between the F and G results. There are two outputs, X and Y. Each one can show F or G (X shows F, Y shows G) or the H result. Each output is either driven directly or taken from its own flip-flop. The flip-flops have a clock enable that can be switched off in the configuration. They also have a synchronous set/reset whose forced value is part of the configuration.

All tables and mode bits come from a 47-bit configuration word. The word is shifted in serially, most significant bit first, while `cfg_en` is high. A small controller tracks the load with three states:
- `ST_EMPTY` is entered on reset.
- `ST_SHIFT` is entered from any state on a clock edge with `cfg_en` high.
- `ST_ACTIVE` is entered from `ST_SHIFT` when `cfg_en` falls after exactly 47 or more shifted bits.
- If `cfg_en` falls after fewer than 47 bits, `ST_SHIFT` returns to `ST_EMPTY`.

In memory mode, F and G become a 16-word by 2-bit writable RAM. The write address is `f_in`. Reads use the normal table lookup path.

Top module: `clb_cell`

## Requirements
- R1: After reset, `ready` is 0 and both `x_out` and `y_out` are 0.
- R2: Loading works as follows.
  - The word is shifted MSB first, one bit per clock edge with `cfg_en` high.
  - The bit layout, from bit 46 down to bit 0, is:
    - bit 46: `ram_mode`
    - bit 45: `sr_val`
    - bit 44: `ce_use`
    - bit 43: `y_reg`
    - bit 42: `x_reg`
    - bit 41: `y_sel`
    - bit 40: `x_sel`
    - bits 39:32: H table
    - bits 31:16: G table
    - bits 15:0: F table
  - `ready` rises on the first edge with `cfg_en` low after 47 or more shifted bits.
  - After fewer bits, that edge leaves `ready` at 0.
- R3: F output equals F-table bit number `f_in`. With `x_sel`=0 and `x_reg`=0, `x_out` shows it combinationally.
- R4: G output equals G-table bit number `g_in`. With `y_sel`=0 and `y_reg`=0, `y_out` shows it combinationally.
- R5: H output equals H-table bit number `{h_in, G, F}`. With `x_sel`/`y_sel`=1 it drives X/Y. With H table 8'hCA and `f_in`=`g_in`, the result is F when `h_in`=0 and G when `h_in`=1, which forms a 5-input function.
- R6: With `x_reg`/`y_reg`=1, the output shows the value its selected function had before the last rising edge.
- R7: With `ce_use`=1 and `ce`=0, the flip-flops hold their value. With `ce_use`=0, `ce` has no effect.
- R8: `sr`=1 loads `sr_val` into both flip-flops on the next edge, even when `ce`=0.
- R9: Memory-mode writes work as follows.
  - With `ram_mode`=1 and `we`=1, a rising edge stores `wdata[0]` in F word `f_in` and `wdata[1]` in G word `f_in`.
  - Reads are combinational through `f_in`/`g_in`.
  - With `ram_mode`=0, `we` changes nothing.
- R10: While `ready` is 0, both outputs are 0. Raising `cfg_en` in `ST_ACTIVE` drops `ready` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| f_in | input | 4 | F table inputs; memory write address |
| g_in | input | 4 | G table inputs |
| h_in | input | 1 | Extra input of the H combiner |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Synchronous set/reset request |
| we | input | 1 | Memory-mode write strobe |
| wdata | input | 2 | Memory-mode write data (bit 0 to F, bit 1 to G) |
| x_out | output | 1 | Cell output X |
| y_out | output | 1 | Cell output Y |
| ready | output | 1 | Configuration complete, cell active |

## Verification
The assertions check the following on every cycle:
- both outputs stay at zero while the cell is unconfigured;
- raising `cfg_en` takes the cell out of the active state;
- a set/reset request forces the registered X value;
- a disabled clock enable freezes X;
- the direct X path matches the F-table bit addressed by `f_in`.

The bench scenarios show the rest:
- the serial word order and the short-load case;
- the full 32-entry five-input mapping through H;
- the one-edge lag of the registered path;
- the memory writes and their read-back through both tables.

// File: rtl/clb_pkg.sv
package clb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_ACTIVE = 2'd2
    } cfg_state_e;

    typedef struct packed {
        logic ram_mode;
        logic sr_val;
        logic ce_use;
        logic y_reg;
        logic x_reg;
        logic y_sel;
        logic x_sel;
    } cell_mode_t;

    localparam int MODE_W = $bits(cell_mode_t);
    localparam int H_K    = 3;
    localparam int H_N    = 1 << H_K;
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      sel,
    output logic              o
);
    assign o = table_bits[sel];
endmodule

// File: rtl/clb_outff.sv
module clb_outff (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ce_use,
    input  logic ce,
    input  logic sr,
    input  logic sr_val,
    input  logic use_reg,
    input  logic d,
    output logic o
);
    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (run && (sr || !ce_use || ce)) begin
            q <= sr ? sr_val : d;
        end
    end

    assign o = use_reg ? q : d;
endmodule

// File: rtl/clb_cfg_ctrl.sv
module clb_cfg_ctrl
    import clb_pkg::*;
#(
    parameter int K = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             we,
    input  logic [1:0]       wdata,
    input  logic [K-1:0]     waddr,
    output logic [(1<<K)-1:0] f_tab,
    output logic [(1<<K)-1:0] g_tab,
    output logic [H_N-1:0]   h_tab,
    output cell_mode_t       mode,
    output logic             ready
);
    localparam int LUT_N = 1 << K;
    localparam int CFG_W = 2 * LUT_N + H_N + MODE_W;
    localparam int CNT_W = $clog2(CFG_W + 1);
    localparam int IDX_W = $clog2(CFG_W);

    cfg_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CFG_W-1:0]   cfg_q;
    logic [IDX_W-1:0]   f_idx, g_idx;
    logic               wr_ok;

    assign f_tab = cfg_q[LUT_N-1:0];
    assign g_tab = cfg_q[2*LUT_N-1:LUT_N];
    assign h_tab = cfg_q[2*LUT_N+H_N-1:2*LUT_N];
    assign mode  = cfg_q[CFG_W-1:CFG_W-MODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (cfg_en) begin
                    state_d = ST_SHIFT;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (cfg_en) begin
                    if (cnt_q != CNT_W'(CFG_W)) cnt_d = cnt_q + CNT_W'(1);
                end else if (cnt_q == CNT_W'(CFG_W)) begin
                    state_d = ST_ACTIVE;
                end else begin
                    state_d = ST_EMPTY;
                end
            end
            ST_ACTIVE: begin
                ready = 1'b1;
                if (cfg_en) begin
                    state_d = ST_SHIFT;
                    cnt_d   = CNT_W'(1);
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign f_idx = IDX_W'(waddr);
    assign g_idx = IDX_W'(LUT_N) + IDX_W'(waddr);
    assign wr_ok = (state_q == ST_ACTIVE) && !cfg_en && mode.ram_mode && we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_en) begin
            cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};
        end else if (wr_ok) begin
            cfg_q[f_idx] <= wdata[0];
            cfg_q[g_idx] <= wdata[1];
        end
    end
endmodule

// File: rtl/clb_cell.sv
module clb_cell
    import clb_pkg::*;
#(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    input  logic [K-1:0] f_in,
    input  logic [K-1:0] g_in,
    input  logic         h_in,
    input  logic         ce,
    input  logic         sr,
    input  logic         we,
    input  logic [1:0]   wdata,
    output logic         x_out,
    output logic         y_out,
    output logic         ready
);
    localparam int LUT_N = 1 << K;

    logic [LUT_N-1:0] f_tab_w, g_tab_w;
    logic [H_N-1:0]   h_tab_w;
    cell_mode_t       mode_w;
    logic             f_o, g_o, h_o;
    logic             x_d, y_d, x_o, y_o;

    clb_cfg_ctrl #(.K(K)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .we(we), .wdata(wdata), .waddr(f_in),
        .f_tab(f_tab_w), .g_tab(g_tab_w), .h_tab(h_tab_w),
        .mode(mode_w), .ready(ready)
    );

    clb_lut #(.K(K))   u_f (.table_bits(f_tab_w), .sel(f_in), .o(f_o));
    clb_lut #(.K(K))   u_g (.table_bits(g_tab_w), .sel(g_in), .o(g_o));
    clb_lut #(.K(H_K)) u_h (.table_bits(h_tab_w), .sel({h_in, g_o, f_o}), .o(h_o));

    assign x_d = mode_w.x_sel ? h_o : f_o;
    assign y_d = mode_w.y_sel ? h_o : g_o;

    clb_outff u_xff (
        .clk(clk), .rst_n(rst_n), .run(ready), .ce_use(mode_w.ce_use),
        .ce(ce), .sr(sr), .sr_val(mode_w.sr_val), .use_reg(mode_w.x_reg),
        .d(x_d), .o(x_o)
    );
    clb_outff u_yff (
        .clk(clk), .rst_n(rst_n), .run(ready), .ce_use(mode_w.ce_use),
        .ce(ce), .sr(sr), .sr_val(mode_w.sr_val), .use_reg(mode_w.y_reg),
        .d(y_d), .o(y_o)
    );

    assign x_out = ready & x_o;
    assign y_out = ready & y_o;
endmodule

// File: rtl/clb_cell_chk.sv
module clb_cell_chk
    import clb_pkg::*;
#(
    parameter int K = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic             ready,
    input logic             x_out,
    input logic             y_out,
    input logic             ce,
    input logic             sr,
    input logic [K-1:0]     f_in,
    input cell_mode_t       mode,
    input logic [(1<<K)-1:0] f_tab
);
    // R10: outputs are silent while unconfigured
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!x_out && !y_out));

    // R10: a new load leaves the active state
    assert_reload_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_en) |=> !ready);

    // R8: set/reset forces the registered X value
    assert_sr_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cfg_en && mode.x_reg && sr) |=> (x_out == $past(mode.sr_val)));

    // R7: disabled clock enable freezes X
    assert_ce_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !cfg_en && mode.x_reg && mode.ce_use && !ce && !sr) |=> $stable(x_out));

    // R3: direct X path shows F table bit
    assert_f_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !mode.x_reg && !mode.x_sel) |-> (x_out == f_tab[f_in]));
endmodule

bind clb_cell clb_cell_chk #(.K(K)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ready(ready),
    .x_out(x_out), .y_out(y_out), .ce(ce), .sr(sr), .f_in(f_in),
    .mode(mode_w), .f_tab(f_tab_w)
);

// File: tb/sim_clb_cell.sv
`timescale 1ns/1ps
module sim_clb_cell;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic       h_in = 1'b0, ce = 1'b0, sr = 1'b0, we = 1'b0;
    logic [1:0] wdata = '0;
    logic       x_out, y_out, ready;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    clb_cell u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .f_in(f_in), .g_in(g_in), .h_in(h_in), .ce(ce), .sr(sr),
        .we(we), .wdata(wdata), .x_out(x_out), .y_out(y_out), .ready(ready)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [46:0] mk(input logic [15:0] f, input logic [15:0] g,
        input logic [7:0] h, input logic xs, input logic ys, input logic xr,
        input logic yr, input logic ceu, input logic srv, input logic ram);
        return {ram, srv, ceu, yr, xr, ys, xs, h, g, f};
    endfunction

    task automatic load(input logic [46:0] v);
        cfg_en = 1'b1;
        for (int i = 46; i >= 0; i--) begin
            cfg_din = v[i];
            step();
        end
        cfg_en = 1'b0;
        step();
        chk("R2 ready after full load", ready, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 ready", ready, 1'b0);
        chk("R1 x_out", x_out, 1'b0);
        chk("R1 y_out", y_out, 1'b0);
    endtask

    task automatic t_short_load();
        cfg_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cfg_din = 1'b1;
            step();
        end
        cfg_en = 1'b0;
        step();
        chk("R2 short load not ready", ready, 1'b0);
        chk("R10 x quiet", x_out, 1'b0);
    endtask

    task automatic t_direct();
        logic [15:0] ft, gt;
        ft = 16'($urandom);
        gt = 16'($urandom);
        load(mk(ft, gt, 8'h00, 0, 0, 0, 0, 0, 0, 0));
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a);
            g_in = 4'(15 - a);
            #1;
            chk("R3 F direct", x_out, ft[a]);
            chk("R4 G direct", y_out, gt[15 - a]);
        end
    endtask

    task automatic t_five_input();
        logic [15:0] ft, gt;
        logic        e;
        ft = 16'($urandom);
        gt = 16'($urandom);
        load(mk(ft, gt, 8'hCA, 1, 1, 0, 1, 0, 0, 0));
        for (int a = 0; a < 32; a++) begin
            f_in = 4'(a);
            g_in = 4'(a);
            h_in = a[4];
            e = a[4] ? gt[a[3:0]] : ft[a[3:0]];
            #1;
            chk("R5 five-input via H", x_out, e);
            step();
            chk("R6 registered H", y_out, e);
        end
        h_in = 1'b0;
    endtask

    task automatic t_enable_sr();
        load(mk(16'h0001, 16'h0000, 8'h00, 0, 0, 1, 0, 1, 1, 0));
        ce = 1'b1; f_in = 4'd0; step();
        chk("R6 registered F", x_out, 1'b1);
        ce = 1'b0; f_in = 4'd1; step();
        chk("R7 ce low holds", x_out, 1'b1);
        ce = 1'b1; step();
        chk("R7 ce high updates", x_out, 1'b0);
        ce = 1'b0; sr = 1'b1; step();
        chk("R8 sr sets with ce low", x_out, 1'b1);
        sr = 1'b0;
        load(mk(16'h0001, 16'h0000, 8'h00, 0, 0, 1, 0, 0, 0, 0));
        ce = 1'b0; f_in = 4'd1; step();
        chk("R7 ce ignored when unused", x_out, 1'b0);
        f_in = 4'd0; step();
        chk("R7 ce ignored when unused", x_out, 1'b1);
        sr = 1'b1; step();
        chk("R8 sr resets", x_out, 1'b0);
        sr = 1'b0;
    endtask

    task automatic t_ram();
        logic [1:0] w;
        load(mk(16'h0000, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 0));
        we = 1'b1; wdata = 2'b11; f_in = 4'd5; step();
        we = 1'b0; g_in = 4'd5; #1;
        chk("R9 we ignored F", x_out, 1'b0);
        chk("R9 we ignored G", y_out, 1'b0);
        load(mk(16'h0000, 16'h0000, 8'h00, 0, 0, 0, 0, 0, 0, 1));
        for (int a = 0; a < 16; a++) begin
            we = 1'b1; f_in = 4'(a);
            wdata = {a[1], a[0] ^ a[3]};
            step();
        end
        we = 1'b0;
        for (int a = 0; a < 16; a++) begin
            f_in = 4'(a); g_in = 4'(a);
            w = {a[1], a[0] ^ a[3]};
            #1;
            chk("R9 RAM read F", x_out, w[0]);
            chk("R9 RAM read G", y_out, w[1]);
        end
    endtask

    task automatic t_reload();
        load(mk(16'hFFFF, 16'h0000, 8'h00, 0, 0, 1, 0, 0, 0, 0));
        step();
        chk("R6 registered one", x_out, 1'b1);
        cfg_en = 1'b1; cfg_din = 1'b0; step();
        chk("R10 reload drops ready", ready, 1'b0);
        chk("R10 x quiet in shift", x_out, 1'b0);
        cfg_en = 1'b0; step();
        chk("R2 one-bit load not ready", ready, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        #1;
        t_reset();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_short_load();
        t_direct();
        t_five_input();
        t_enable_sr();
        t_ram();
        t_reload();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule